// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block collects up to eight interrupt request lines and presents a single interrupt to a processor. Each line is synchronised and edge-detected. A rising edge sets that line's bit in a pending register, but only if the line's mask bit is clear. The mask filters only the path into the pending register. A bit that is already pending keeps the interrupt asserted even after its line is masked. The interrupt drops only when the processor accepts it with an acknowledge pulse.

On an accepted acknowledge, the highest-numbered pending line wins. Its pending bit moves into an in-service register, and `vec_o` shows a programmable base plus the line number during that same cycle. While a line is in service, pending lines of equal or lower number cannot raise the interrupt. An end-of-interrupt command, written through the small register port, retires the highest in-service line.

A two-state machine drives the interrupt output:
- `ST_QUIET` to `ST_RAISED` when the next pending and in-service contents contain a pending line that outranks every in-service line.
- `ST_RAISED` to `ST_QUIET` on an accepted acknowledge that leaves no such line.
- Otherwise each state holds.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending register, the in-service register, the mask and the vector base all read 0, and `int_o` is low.
- R2: A rising edge on an unmasked `req_i[n]` sets pending bit n, and `int_o` is high at the third rising clock edge after the input rises. A line held high sets its bit only once.
- R3: A mask bit of 1 stops its line from setting its pending bit, so the edge is lost and `int_o` stays low. A mask bit of 0 lets the line through.
- R4: Writing a mask bit to 1 after its pending bit is set leaves the pending bit set and leaves `int_o` high.
- R5: Once high, `int_o` falls only in the cycle after an accepted acknowledge. An `ack_i` pulse while `int_o` is low changes nothing.
- R6: During an accepted `ack_i` cycle, `vec_o` equals the base plus the index of the highest pending line. On the next edge that pending bit clears and the matching in-service bit sets.
- R7: Two lines that rise in the same cycle both become pending. The acknowledge takes the higher-numbered one, and the other stays pending.
- R8: While in-service bit k is set, pending lines numbered k or lower keep `int_o` low, and a pending line numbered above k raises it.
- R9: End-of-interrupt clears the highest set in-service bit. A lower pending line then raises `int_o` at the same edge, even if its mask bit is 1.
- R10: End-of-interrupt with no in-service bit set changes nothing.
- R11: Register map on `addr_i`:
  - address 0: mask, read and write.
  - address 1: vector base, read and write.
  - address 2: reads the pending register; a write to it issues end-of-interrupt and its data is ignored.
  - address 3: reads the in-service register.
- R12: An accepted acknowledge and an end-of-interrupt in the same cycle both take effect. The in-service bit that was highest before that edge is cleared, and the winner's bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Asynchronous request lines, rising-edge sensitive |
| ack_i | input | 1 | One-cycle acknowledge from the processor |
| int_o | output | 1 | Interrupt to the processor |
| vec_o | output | 8 | Vector: base plus winning line index |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational on `addr_i`) |

## Verification
The acknowledge and the end-of-interrupt write both update the in-service register, and they can fall in the same cycle. The bench drives `ack_i` together with a write to address 2 while line 2 is in service and line 7 is pending. It expects vector base+7, and an in-service register holding only bit 7 afterwards. A second overlap is a line that is masked after it has latched. The bench checks that it still holds `int_o` and that it reasserts `int_o` once end-of-interrupt clears the blocking in-service bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_BASE = 2'd1,
        REG_PEND = 2'd2,
        REG_SERV = 2'd3
    } irqc_reg_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irqc_state_e;

endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
    parameter int N_LINES = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] async_i,
    output logic [N_LINES-1:0] rise_o
);
    logic [N_LINES-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N_LINES = 8,
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] bits_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (bits_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_LINES-1:0] req_i,
    input  logic              ack_i,
    output logic              int_o,
    output logic [DATA_W-1:0] vec_o,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    irqc_state_e        state_q, state_d;
    logic [N_LINES-1:0] mask_q, irr_q, isr_q;
    logic [DATA_W-1:0]  base_q;
    logic [N_LINES-1:0] rise, irr_nxt, isr_nxt, ack_clr, eoi_clr;
    logic               win_any, srv_any, nirr_any, nsrv_any, eligible_nxt;
    logic [IDX_W-1:0]   win_idx, srv_idx, nirr_idx, nsrv_idx;
    logic               take, eoi;

    irqc_edge_sync #(.N_LINES(N_LINES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(req_i), .rise_o(rise)
    );

    irqc_prio #(.N_LINES(N_LINES)) u_win      (.bits_i(irr_q),   .any_o(win_any),  .idx_o(win_idx));
    irqc_prio #(.N_LINES(N_LINES)) u_srv      (.bits_i(isr_q),   .any_o(srv_any),  .idx_o(srv_idx));
    irqc_prio #(.N_LINES(N_LINES)) u_nxt_pend (.bits_i(irr_nxt), .any_o(nirr_any), .idx_o(nirr_idx));
    irqc_prio #(.N_LINES(N_LINES)) u_nxt_serv (.bits_i(isr_nxt), .any_o(nsrv_any), .idx_o(nsrv_idx));

    // Acknowledge is honoured only while the interrupt is being presented.
    assign take = ack_i && (state_q == ST_RAISED) && win_any;
    assign eoi  = wr_en_i && (irqc_reg_e'(addr_i) == REG_PEND);

    always_comb begin
        ack_clr = take ? (N_LINES'(1) << win_idx) : '0;
        eoi_clr = (eoi && srv_any) ? (N_LINES'(1) << srv_idx) : '0;
        // The mask filters fresh edges only; latched bits are left alone.
        irr_nxt = (irr_q & ~ack_clr) | (rise & ~mask_q);
        isr_nxt = (isr_q & ~eoi_clr) | ack_clr;
        eligible_nxt = nirr_any && (!nsrv_any || (nirr_idx > nsrv_idx));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (eligible_nxt) state_d = ST_RAISED;
            ST_RAISED: if (take && !eligible_nxt) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irr_q  <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            base_q <= '0;
        end else begin
            irr_q <= irr_nxt;
            isr_q <= isr_nxt;
            if (wr_en_i && irqc_reg_e'(addr_i) == REG_MASK) mask_q <= wdata_i[N_LINES-1:0];
            if (wr_en_i && irqc_reg_e'(addr_i) == REG_BASE) base_q <= wdata_i;
        end
    end

    always_comb begin
        int_o   = (state_q == ST_RAISED);
        vec_o   = base_q + DATA_W'(win_idx);
        rdata_o = '0;
        unique case (irqc_reg_e'(addr_i))
            REG_MASK: rdata_o[N_LINES-1:0] = mask_q;
            REG_BASE: rdata_o = base_q;
            REG_PEND: rdata_o[N_LINES-1:0] = irr_q;
            REG_SERV: rdata_o[N_LINES-1:0] = isr_q;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N_LINES = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               ack_i,
    input logic               int_o,
    input logic               wr_en_i,
    input logic [1:0]         addr_i,
    input logic [N_LINES-1:0] irr_q,
    input logic [N_LINES-1:0] isr_q
);
    logic eoi_w;
    assign eoi_w = wr_en_i && (addr_i == 2'd2);

    assert_int_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(int_o) |-> $past(ack_i));

    assert_ack_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !int_o && !wr_en_i) |=> (isr_q == $past(isr_q)));

    assert_pending_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_i |=> ((irr_q & $past(irr_q)) == $past(irr_q)));

    assert_take_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && int_o && !eoi_w) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

    assert_eoi_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_w && !ack_i && (isr_q == '0)) |=> (isr_q == '0));

    assert_int_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |-> (irr_q != '0));
endmodule

bind irq_prio_ctrl irqc_checker #(.N_LINES(N_LINES)) u_irqc_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .int_o(int_o),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       ack = 1'b0;
    logic       int_w;
    logic [7:0] vec;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack), .int_o(int_w),
        .vec_o(vec), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic raise(input logic [7:0] lines);
        @(negedge clk);
        req = req | lines;
        repeat (3) @(negedge clk);
    endtask

    task automatic lower(input logic [7:0] lines);
        req = req & ~lines;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_ack(input logic [7:0] exp, input string tag, input bit with_eoi);
        @(negedge clk);
        ack = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        if (with_eoi) begin
            wr_en = 1'b1; addr = 2'd2; wdata = 8'hFF;
        end
        @(negedge clk);
        ack = 1'b0;
        wr_en = 1'b0;
    endtask

    // Monitor: compares vec_o in each acknowledge cycle against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (ack && exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, vec, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 int", {7'd0, int_w}, 8'h00);
        chk_reg("R1 mask", 2'd0, 8'h00);
        chk_reg("R1 base", 2'd1, 8'h00);
        chk_reg("R1 irr", 2'd2, 8'h00);
        chk_reg("R1 isr", 2'd3, 8'h00);

        // R11 base register
        wr(2'd1, 8'h20);
        chk_reg("R11 base", 2'd1, 8'h20);

        // R2 single line
        raise(8'h08);
        chk_reg("R2 irr", 2'd2, 8'h08);
        check("R2 int", {7'd0, int_w}, 8'h01);
        lower(8'h08);
        do_ack(8'h23, "R6 vec", 0);
        check("R6 int", {7'd0, int_w}, 8'h00);
        chk_reg("R6 irr", 2'd2, 8'h00);
        chk_reg("R6 isr", 2'd3, 8'h08);
        wr(2'd2, 8'h00);
        chk_reg("R9 isr", 2'd3, 8'h00);

        // R10 empty EOI
        wr(2'd2, 8'h00);
        chk_reg("R10 isr", 2'd3, 8'h00);
        chk_reg("R10 irr", 2'd2, 8'h00);
        check("R10 int", {7'd0, int_w}, 8'h00);

        // R5 ack while quiet
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk_reg("R5 isr", 2'd3, 8'h00);
        check("R5 int", {7'd0, int_w}, 8'h00);

        // R3 masked line
        wr(2'd0, 8'h20);
        chk_reg("R11 mask", 2'd0, 8'h20);
        raise(8'h20);
        chk_reg("R3 irr", 2'd2, 8'h00);
        check("R3 int", {7'd0, int_w}, 8'h00);
        lower(8'h20);
        wr(2'd0, 8'h00);

        // R4 mask after latch
        raise(8'h02);
        lower(8'h02);
        wr(2'd0, 8'h02);
        repeat (5) @(negedge clk);
        chk_reg("R4 irr", 2'd2, 8'h02);
        check("R4 int", {7'd0, int_w}, 8'h01);
        do_ack(8'h21, "R5 vec", 0);
        check("R5 int drop", {7'd0, int_w}, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);

        // R7 simultaneous lines 0 and 4
        raise(8'h11);
        lower(8'h11);
        chk_reg("R7 irr", 2'd2, 8'h11);
        check("R7 int", {7'd0, int_w}, 8'h01);
        wr(2'd0, 8'h01);
        do_ack(8'h24, "R7 vec", 0);
        chk_reg("R7 irr left", 2'd2, 8'h01);
        chk_reg("R7 isr", 2'd3, 8'h10);
        check("R8 int blocked", {7'd0, int_w}, 8'h00);

        // R8 lower blocked, higher nests
        raise(8'h04);
        lower(8'h04);
        chk_reg("R8 irr", 2'd2, 8'h05);
        check("R8 int low", {7'd0, int_w}, 8'h00);
        raise(8'h40);
        lower(8'h40);
        check("R8 int nest", {7'd0, int_w}, 8'h01);
        do_ack(8'h26, "R8 vec", 0);
        chk_reg("R8 isr", 2'd3, 8'h50);
        check("R8 int after", {7'd0, int_w}, 8'h00);

        // R9 EOI order and reassert of a masked latched line
        wr(2'd2, 8'h00);
        chk_reg("R9 isr top", 2'd3, 8'h10);
        check("R9 int still", {7'd0, int_w}, 8'h00);
        wr(2'd2, 8'h00);
        chk_reg("R9 isr empty", 2'd3, 8'h00);
        check("R9 reassert", {7'd0, int_w}, 8'h01);

        // R12 ack and EOI together
        do_ack(8'h22, "R12 pre vec", 0);
        chk_reg("R12 isr pre", 2'd3, 8'h04);
        raise(8'h80);
        lower(8'h80);
        check("R12 int", {7'd0, int_w}, 8'h01);
        do_ack(8'h27, "R12 vec", 1);
        chk_reg("R12 isr", 2'd3, 8'h80);
        chk_reg("R12 irr", 2'd2, 8'h01);
        check("R12 int", {7'd0, int_w}, 8'h00);
        wr(2'd2, 8'h00);
        check("R9 masked line", {7'd0, int_w}, 8'h01);
        do_ack(8'h20, "R9 vec", 0);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);

        // R2 held level fires once
        raise(8'h08);
        do_ack(8'h23, "R2 vec", 0);
        wr(2'd2, 8'h00);
        repeat (6) @(negedge clk);
        chk_reg("R2 no retrigger", 2'd2, 8'h00);
        check("R2 int quiet", {7'd0, int_w}, 8'h00);
        lower(8'h08);

        repeat (4) @(negedge clk);
        check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule